// File: doc/BRIEF.md
# Sample-Only Boundary-Scan Test Port

This block is the serial test port of a memory macro. A four-wire serial interface, made of test clock, mode select, serial data in and serial data out, steps a sixteen-state controller. The controller moves bits through one of four shift paths: a 3-bit instruction register, a 32-bit identification register, a 1-bit bypass register and a 70-bit boundary register. The boundary register takes a snapshot of a parallel vector of pin values. Its contents can only be read out. Nothing that is shifted in is ever driven back onto the pins.

The instruction set is reduced and does not follow the usual standard. Two codes, all-zero and a private sample-with-isolation code, capture the pins and raise an isolation output. That output tells the memory to hold its data outputs at high impedance for as long as either code stays loaded. A plain sample code captures the pins and has no other effect. Update-DR never loads anything. There is no separate test reset pin. The controller returns to test-logic-reset after five rising clock edges with mode select high, or on the power-on reset.

Top module: `scan_tap`

## Requirements
- R1: The controller enters test-logic-reset after five consecutive rising tck edges with tms high, starting from any state. Asserting por_n low also puts it there at once and clears mem_hiz. In test-logic-reset the instruction becomes IDCODE (001).
- R2: tdo and tdo_oe change only on falling tck edges. tdo_oe is high only while the controller is in shift-IR or shift-DR.
- R3: Capture-IR loads the instruction shift path with 001. Instruction bits are shifted in and out least significant bit first.
- R4: A newly shifted instruction takes effect only when the controller passes through update-IR. Before that, mem_hiz and the selected data path keep following the old instruction. After reset, IDCODE is the active instruction.
- R5: Under IDCODE (001), capture-DR loads the 32-bit identification value 0x1A5CE0F1. Its bit 0 is 1, and it is shifted out first.
- R6: Under BYPASS (111), the data path is a single bit that captures 0. A bit shifted in on tdi appears on tdo one shift later.
- R7: The reserved codes 011, 101 and 110 behave exactly like BYPASS and leave mem_hiz low.
- R8: Codes 000 and 010 capture pins_in into the 70-bit boundary register and select it. pins_in[0] is the first bit out of tdo. mem_hiz is high for as long as either code is the active instruction.
- R9: Code 100 captures and shifts the boundary register like R8 but keeps mem_hiz low. Passing through update-DR under this code leaves mem_hiz low.
- R10: Boundary positions 2 and 36 are placeholders. Counting from tdo as position 1, these are pins_in[1] and pins_in[35], and they always capture 1 whatever the pin value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pins_in | input | 70 | Parallel pin snapshot for the boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Drive enable for tdo |
| mem_hiz | output | 1 | Forces memory data outputs to high impedance |

## Verification
The controller state moves on the rising edge that samples tms. A capture happens on the rising edge that leaves a capture state. The first captured bit reaches tdo on the falling edge that follows. Each further bit appears one falling edge after the rising edge that shifted it. An instruction becomes active on the rising edge that leaves update-IR, so mem_hiz settles in the same half-cycle. The bench drives tms and tdi during the low phase and reads tdo, tdo_oe and mem_hiz 1 ns after a falling edge. One directed check also reads tdo just after a rising edge, to confirm that it has not moved yet.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET    = 4'h0,
    TS_IDLE     = 4'h1,
    TS_SEL_DR   = 4'h2,
    TS_CAP_DR   = 4'h3,
    TS_SHIFT_DR = 4'h4,
    TS_EXIT1_DR = 4'h5,
    TS_PAUSE_DR = 4'h6,
    TS_EXIT2_DR = 4'h7,
    TS_UPD_DR   = 4'h8,
    TS_SEL_IR   = 4'h9,
    TS_CAP_IR   = 4'hA,
    TS_SHIFT_IR = 4'hB,
    TS_EXIT1_IR = 4'hC,
    TS_PAUSE_IR = 4'hD,
    TS_EXIT2_IR = 4'hE,
    TS_UPD_IR   = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'd0,
    PATH_IDENT  = 2'd1,
    PATH_BOUND  = 2'd2
  } dr_path_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb,
  output dr_path_e        path,
  output logic            hiz
);

  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] sh_d;
  logic [IR_W-1:0] ir_d;
  logic            sh_en;
  logic            ir_en;

  // shift path: capture constant, shift LSB first
  assign sh_en = (state == TS_CAP_IR) || (state == TS_SHIFT_IR);

  always_comb begin
    sh_d = sh_q;
    if (state == TS_CAP_IR)        sh_d = IR_CAPTURE;
    else if (state == TS_SHIFT_IR) sh_d = {tdi, sh_q[IR_W-1:1]};
  end

  // active instruction: changes only in reset or update
  assign ir_en = (state == TS_RESET) || (state == TS_UPD_IR);

  always_comb begin
    ir_d = ir_q;
    if (state == TS_RESET)       ir_d = OP_IDCODE;
    else if (state == TS_UPD_IR) ir_d = sh_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= IR_CAPTURE;
      ir_q <= OP_IDCODE;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign ir_lsb = sh_q[0];

  // decode: unlisted codes fall back to the bypass path
  always_comb begin
    path = PATH_BYPASS;
    hiz  = 1'b0;
    case (ir_q)
      OP_EXTEST: begin path = PATH_BOUND; hiz = 1'b1; end
      OP_SAMPZ:  begin path = PATH_BOUND; hiz = 1'b1; end
      OP_SAMPLE: path = PATH_BOUND;
      OP_IDCODE: path = PATH_IDENT;
      default:   path = PATH_BYPASS;
    endcase
  end

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int                  BSR_LEN  = 70,
  parameter int                  ID_W     = 32,
  parameter logic [ID_W-1:0]     ID_VALUE = 32'h1A5C_E0F1,
  parameter logic [BSR_LEN-1:0]  PH_MASK  = '0
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tdi,
  input  tap_state_e         state,
  input  dr_path_e           path,
  input  logic [BSR_LEN-1:0] pins,
  output logic               dr_lsb
);

  logic               cap;
  logic               shf;
  logic [ID_W-1:0]    id_q,  id_d;
  logic               byp_q, byp_d;
  logic [BSR_LEN-1:0] bsr_q, bsr_d;
  logic [BSR_LEN-1:0] cap_vec;
  logic               id_en, byp_en, bsr_en;

  assign cap = (state == TS_CAP_DR);
  assign shf = (state == TS_SHIFT_DR);

  // placeholder positions read as constant one
  for (genvar g = 0; g < BSR_LEN; g++) begin : g_cap
    if (PH_MASK[g]) begin : g_ph
      assign cap_vec[g] = 1'b1;
    end else begin : g_pin
      assign cap_vec[g] = pins[g];
    end
  end

  assign id_en  = (cap || shf) && (path == PATH_IDENT);
  assign byp_en = (cap || shf) && (path == PATH_BYPASS);
  assign bsr_en = (cap || shf) && (path == PATH_BOUND);

  always_comb begin
    id_d  = cap ? ID_VALUE : {tdi, id_q[ID_W-1:1]};
    byp_d = cap ? 1'b0     : tdi;
    bsr_d = cap ? cap_vec  : {tdi, bsr_q[BSR_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      byp_q <= 1'b0;
      bsr_q <= '0;
    end else begin
      if (id_en)  id_q  <= id_d;
      if (byp_en) byp_q <= byp_d;
      if (bsr_en) bsr_q <= bsr_d;
    end
  end

  always_comb begin
    case (path)
      PATH_IDENT: dr_lsb = id_q[0];
      PATH_BOUND: dr_lsb = bsr_q[0];
      default:    dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int                 BSR_LEN  = 70,
  parameter logic [31:0]        ID_VALUE = 32'h1A5C_E0F1,
  parameter logic [BSR_LEN-1:0] PH_MASK  = (BSR_LEN)'(64'h0000_0008_0000_0002)
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               mem_hiz
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_n;
  tap_state_e             state;
  logic [IR_W-1:0]        ir_q;
  logic                   ir_lsb;
  logic                   dr_lsb;
  dr_path_e               path;
  logic                   shifting;
  logic                   tdo_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rs_q[SYNC_STAGES-1];

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  scan_tap_ir u_ir (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .ir_q   (ir_q),
    .ir_lsb (ir_lsb),
    .path   (path),
    .hiz    (mem_hiz)
  );

  scan_tap_dr #(
    .BSR_LEN  (BSR_LEN),
    .ID_W     (32),
    .ID_VALUE (ID_VALUE),
    .PH_MASK  (PH_MASK)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .path   (path),
    .pins   (pins_in),
    .dr_lsb (dr_lsb)
  );

  assign shifting = (state == TS_SHIFT_IR) || (state == TS_SHIFT_DR);
  assign tdo_d    = (state == TS_SHIFT_IR) ? ir_lsb : dr_lsb;

  // output stage on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shifting;
      if (shifting) tdo <= tdo_d;
    end
  end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input logic            tdo_oe,
  input logic            mem_hiz,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= 3'd0;
    else if (!tms)        hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_cnt == 3'd5) |-> (state == TS_RESET)); // R1

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((state == TS_SHIFT_IR) || (state == TS_SHIFT_DR))); // R2

  AST_IR_HELD: assert property (@(posedge tck) disable iff (!rst_n)
    ((state != TS_UPD_IR) && (state != TS_RESET)) |=> $stable(ir)); // R4

  AST_HIZ_AFTER_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(mem_hiz) |-> ($past(state) == TS_UPD_IR)); // R8

  AST_RESET_CLEARS_HIZ: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET) |=> !mem_hiz); // R1

endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck     (tck),
  .rst_n   (rst_n),
  .tms     (tms),
  .tdo_oe  (tdo_oe),
  .mem_hiz (mem_hiz),
  .state   (state),
  .ir      (ir_q)
);

// File: tb/scan_tap_bench.sv
module scan_tap_bench;

  localparam int          BL    = 70;
  localparam logic [31:0] IDV   = 32'h1A5C_E0F1;
  localparam logic [BL-1:0] PHM = 70'h8_0000_0002;

  // {code[5:3], expected hiz[2], path[1:0]: 0 bypass, 1 ident, 2 boundary}
  localparam logic [5:0] VEC [0:7] = '{
    6'b000_1_10, 6'b001_0_01, 6'b010_1_10, 6'b011_0_00,
    6'b100_0_10, 6'b101_0_00, 6'b110_0_00, 6'b111_0_00
  };

  logic          tck = 1'b0;
  logic          por_n;
  logic          tms;
  logic          tdi;
  logic [BL-1:0] pins;
  logic          tdo;
  logic          tdo_oe;
  logic          mem_hiz;
  int            n_chk = 0;
  int            n_err = 0;

  always #5 tck = ~tck;

  scan_tap u_scan_tap (
    .tck     (tck),
    .por_n   (por_n),
    .tms     (tms),
    .tdi     (tdi),
    .pins_in (pins),
    .tdo     (tdo),
    .tdo_oe  (tdo_oe),
    .mem_hiz (mem_hiz)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from run-test-idle, back to run-test-idle
  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, code[i]);
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] got);
    got = '0;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      got[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic power_up();
    por_n = 1'b1;
    repeat (3) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [2:0]   cap;
    logic [127:0] got;
    logic [127:0] expv;
    tms = 1'b1; tdi = 1'b0; por_n = 1'b0; pins = '0;
    repeat (3) @(negedge tck);
    #1;
    chk("R1 reset tdo_oe", 128'(tdo_oe), 128'(0));
    chk("R1 reset mem_hiz", 128'(mem_hiz), 128'(0));
    power_up();
    chk("R2 idle tdo_oe", 128'(tdo_oe), 128'(0));
    scan_dr(32, '0, got);
    chk("R4 default IDCODE", got, 128'(IDV));

    // vector walk over all instruction codes
    for (int k = 0; k < 8; k++) begin
      logic [2:0] code;
      code = VEC[k][5:3];
      pins = {6'(k), 64'hA5A5_F00F_1234_C3C3 ^ {8{8'(k)}}};
      load_ir(code, cap);
      chk("R3 capture-IR", 128'(cap), 128'(3'b001));
      chk((code == 3'b100) ? "R9 hiz" : ((VEC[k][1:0] == 2'd2) ? "R8 hiz" : "R7 hiz"),
          128'(mem_hiz), 128'(VEC[k][2]));
      case (VEC[k][1:0])
        2'd1: begin
          scan_dr(32, '0, got);
          chk("R5 ident", got, 128'(IDV));
        end
        2'd2: begin
          scan_dr(BL, '0, got);
          expv = 128'(pins | PHM);
          chk((code == 3'b100) ? "R9 sample" : "R8 capture", got, expv);
          chk((code == 3'b100) ? "R9 after update-DR" : "R8 after update-DR",
              128'(mem_hiz), 128'(VEC[k][2]));
        end
        default: begin
          scan_dr(4, 128'(4'b1011), got);
          chk((code == 3'b111) ? "R6 bypass" : "R7 reserved", got, 128'(4'b0110));
        end
      endcase
    end

    // R10 placeholders with all pins low
    pins = '0;
    load_ir(3'b100, cap);
    scan_dr(BL, '0, got);
    chk("R10 placeholders", got, 128'(PHM));

    // R2 output moves on falling edge only
    load_ir(3'b001, cap);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    chk("R2 shift tdo_oe", 128'(tdo_oe), 128'(1));
    chk("R2 first bit", 128'(tdo), 128'(1));
    tms = 1'b0; tdi = 1'b0;
    @(posedge tck); #1;
    chk("R2 held past rising edge", 128'(tdo), 128'(1));
    @(negedge tck); #1;
    chk("R2 after falling edge", 128'(tdo), 128'(0));
    tick(1'b1, 1'b0);
    chk("R2 exit tdo_oe", 128'(tdo_oe), 128'(0));
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);

    // R4 instruction effective only at update-IR
    load_ir(3'b000, cap);
    chk("R8 extest hiz", 128'(mem_hiz), 128'(1));
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1); tick(1'b1, 1'b1);
    chk("R4 hiz before update", 128'(mem_hiz), 128'(1));
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R4 hiz after update", 128'(mem_hiz), 128'(0));

    // R1 five tms-high edges from shift-DR
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    repeat (5) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    scan_dr(32, '0, got);
    chk("R1 tms reset to IDCODE", got, 128'(IDV));

    // R1 power-on reset mid-operation
    load_ir(3'b010, cap);
    chk("R8 sample-z hiz", 128'(mem_hiz), 128'(1));
    por_n = 1'b0;
    #2;
    chk("R1 por clears hiz", 128'(mem_hiz), 128'(0));
    @(negedge tck); #1;
    power_up();
    scan_dr(32, '0, got);
    chk("R1 por to IDCODE", got, 128'(IDV));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule